// File: doc/BRIEF.md
# GPIO Expander Port Register Bank

This block is the register file behind a 16-pin general-purpose I/O expander. The pins form two 8-bit ports. Each port has four byte registers: a sampled input view, an output latch, a polarity mask and a direction mask. The eight registers are paired by function, and the two registers of a pair cover port 0 and port 1. A serial bus front end, which is not part of this block, loads a 3-bit register pointer and then issues one write or read strobe for each byte. After every accepted byte access the pointer moves to the other register of the same pair. A master can therefore stream alternating port-0 and port-1 bytes without reloading the pointer.

Raw pin levels enter through a two-flop synchronizer. The input view is the synchronized level XOR the polarity mask. The direction mask produces the per-pin output enables. Output latch bits reach the pins only where the pin is an output. Read data is registered and holds its value between reads.

Top module: `gpx_regbank`

## Requirements
- R1: After reset every direction bit is 1, every output latch and polarity bit is 0, the pointer is 0, and rd_data, pin_out and pin_oe are all 0.
- R2: A ptr_load sets the pointer to ptr_idx. Each accepted byte write or read flips pointer bit 0, so 7 goes to 6 and 0 goes to 1. Pointer index bits [2:1] pick the pair (0 input, 1 output latch, 2 polarity, 3 direction) and bit 0 picks the port.
- R3: pin_oe for a pin is 1 when its direction bit is 0 and 0 when its direction bit is 1. Port 0 drives pins [7:0] and port 1 drives pins [15:8].
- R4: pin_out for a pin equals its output latch bit when the pin is an output and is 0 when the pin is an input.
- R5: Reading an output latch register returns the stored byte, whatever the pin levels are.
- R6: Reading an input register returns the synchronized pin byte, with every bit whose polarity bit is 1 inverted.
- R7: Writes to the input registers (pointer 0 or 1) change no register, but they still flip the pointer.
- R8: A read accepted on clock edge k returns the pin levels sampled at edge k-2.
- R9: A byte write changes only the register the pointer addresses.
- R10: While ptr_load is high, wr_stb and rd_stb are ignored: no register is written and rd_data does not change.
- R11: When wr_stb and rd_stb are high together, the write is performed, the read is dropped, rd_data holds its value and the pointer flips once.
- R12: rd_data is registered. It updates one edge after an accepted read and holds its value otherwise.

Write-side timing, shown at the ports:

| Edge | Inputs sampled | State after the edge |
|------|----------------|----------------------|
| k | wr_stb=1, ptr_load=0, pointer=p | addressed register of p holds wr_data (R9, R7 when p is 0 or 1); pointer is p with bit 0 flipped (R2) |
| k | ptr_load=1 | pointer is ptr_idx; no register or rd_data changes (R10) |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_load | input | 1 | Load the pointer from ptr_idx |
| ptr_idx | input | 3 | Register index to load |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to write |
| rd_stb | input | 1 | Byte read strobe |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| cur_ptr | output | 3 | Current register pointer |
| rd_data | output | 8 | Registered read byte |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Per-pin output enables |

## Verification
The assertions check the following properties on every cycle:
- the pointer's load and bit-0 flip;
- that no pin shows an output level while its enable is low;
- that rd_data holds unless a read is accepted;
- that input-register writes and load cycles leave the pins untouched.

Only the bench's scenarios can show the following:
- the actual read values, including polarity inversion and output-latch readback against differing pins;
- the two-edge synchronizer latency;
- that a write lands in exactly one register.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PTR_W     = 3;
  localparam int NUM_PORTS = 2;

  typedef enum logic [1:0] {
    RK_INPUT  = 2'd0,
    RK_OUTPUT = 2'd1,
    RK_POLAR  = 2'd2,
    RK_CONFIG = 2'd3
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input logic [PTR_W-1:0] p);
    return reg_kind_e'(p[PTR_W-1:1]);
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_ptr.sv
module gpx_ptr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] idx,
  input  logic         step,
  output logic [W-1:0] ptr
);
  localparam logic [W-1:0] FLIP = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= idx;
    else if (step) ptr <= ptr ^ FLIP;
  end
endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_out,
  input  logic         we_pol,
  input  logic         we_cfg,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins_sync,
  output logic [W-1:0] out_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] in_view
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      pol_q <= '0;
      cfg_q <= '1;
    end else begin
      if (we_out) out_q <= wdata;
      if (we_pol) pol_q <= wdata;
      if (we_cfg) cfg_q <= wdata;
    end
  end

  assign in_view = pins_sync ^ pol_q;
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
  import gpx_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ptr_load,
  input  logic [PTR_W-1:0]              ptr_idx,
  input  logic                          wr_stb,
  input  logic [PORT_W-1:0]             wr_data,
  input  logic                          rd_stb,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [PTR_W-1:0]              cur_ptr,
  output logic [PORT_W-1:0]             rd_data,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe
);
  localparam int TW = NUM_PORTS * PORT_W;

  logic              acc_wr, acc_rd;
  logic [TW-1:0]     pins_s;
  logic [PORT_W-1:0] out_q  [NUM_PORTS];
  logic [PORT_W-1:0] pol_q  [NUM_PORTS];
  logic [PORT_W-1:0] cfg_q  [NUM_PORTS];
  logic [PORT_W-1:0] in_v   [NUM_PORTS];
  logic [PORT_W-1:0] rd_next;
  reg_kind_e         kind;
  logic              sel;

  assign acc_wr = wr_stb & ~ptr_load;
  assign acc_rd = rd_stb & ~wr_stb & ~ptr_load;
  assign kind   = kind_of(cur_ptr);
  assign sel    = cur_ptr[0];

  gpx_ptr #(.W(PTR_W)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .load (ptr_load),
    .idx  (ptr_idx),
    .step (acc_wr | acc_rd),
    .ptr  (cur_ptr)
  );

  gpx_sync #(.W(TW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = acc_wr && (sel == 1'(p));

    gpx_port #(.W(PORT_W)) u_port (
      .clk       (clk),
      .rst       (rst),
      .we_out    (hit && kind == RK_OUTPUT),
      .we_pol    (hit && kind == RK_POLAR),
      .we_cfg    (hit && kind == RK_CONFIG),
      .wdata     (wr_data),
      .pins_sync (pins_s[p*PORT_W +: PORT_W]),
      .out_q     (out_q[p]),
      .pol_q     (pol_q[p]),
      .cfg_q     (cfg_q[p]),
      .in_view   (in_v[p])
    );

    assign pin_oe [p*PORT_W +: PORT_W] = ~cfg_q[p];
    assign pin_out[p*PORT_W +: PORT_W] = out_q[p] & ~cfg_q[p];
  end

  always_comb begin
    case (kind)
      RK_INPUT:  rd_next = in_v[sel];
      RK_OUTPUT: rd_next = out_q[sel];
      RK_POLAR:  rd_next = pol_q[sel];
      default:   rd_next = cfg_q[sel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (acc_rd) rd_data <= rd_next;
  end
endmodule

// File: rtl/gpx_regbank_chk.sv
module gpx_regbank_chk #(
  parameter int PW = 8,
  parameter int TW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          ptr_load,
  input logic [AW-1:0] ptr_idx,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic [AW-1:0] cur_ptr,
  input logic [PW-1:0] rd_data,
  input logic [TW-1:0] pin_out,
  input logic [TW-1:0] pin_oe
);
  // R2: pointer load
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> cur_ptr == $past(ptr_idx));

  // R2: pointer flips bit 0 after an accepted byte
  p_ptr_flip_r2: assert property (@(posedge clk) disable iff (rst)
    (!ptr_load && (wr_stb || rd_stb)) |=> cur_ptr == ($past(cur_ptr) ^ AW'(1)));

  // R4: an input pin never shows an output level
  p_no_drive_on_input_r4: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  // R7: an input-register write leaves the pins alone
  p_input_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !ptr_load && cur_ptr[AW-1:1] == '0) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R10: a load cycle blocks both strobes
  p_load_blocks_strobes_r10: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> ($stable(pin_oe) && $stable(pin_out) && $stable(rd_data)));

  // R11: a write drops a concurrent read
  p_write_beats_read_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && rd_stb) |=> $stable(rd_data));

  // R12: rd_data holds unless a read is accepted
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && !wr_stb && !ptr_load) |=> $stable(rd_data));
endmodule

bind gpx_regbank gpx_regbank_chk #(
  .PW(PORT_W),
  .TW(TW),
  .AW(gpx_pkg::PTR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ptr_load (ptr_load),
  .ptr_idx  (ptr_idx),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .cur_ptr  (cur_ptr),
  .rd_data  (rd_data),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe)
);

// File: tb/gpx_regbank_test.sv
module gpx_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_load = 1'b0;
  logic [2:0]  ptr_idx = '0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_stb = 1'b0;
  logic [15:0] pin_in = '0;
  logic [2:0]  cur_ptr;
  logic [7:0]  rd_data;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;

  int   n_chk  = 0;
  int   n_fail = 0;
  logic fire   = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  gpx_regbank uut (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_idx(ptr_idx),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .pin_in(pin_in),
    .cur_ptr(cur_ptr), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares each accepted read against the scoreboard queue
  always @(posedge clk) fire <= rd_stb & ~wr_stb & ~ptr_load & ~rst;

  always @(negedge clk) begin
    if (fire) begin
      if (exp_q.size() == 0) chk("read with no expected item", 32'(rd_data), 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), 32'(rd_data), 32'(exp_q.pop_front()));
    end
  end

  // driver tasks: called just after a falling edge
  task automatic ld(input logic [2:0] idx);
    ptr_load = 1'b1; ptr_idx = idx;
    @(negedge clk);
    ptr_load = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    chk("R1 pin_oe", 32'(pin_oe), 32'h0);
    chk("R1 pin_out", 32'(pin_out), 32'h0);
    chk("R1 rd_data", 32'(rd_data), 32'h0);
    chk("R1 ptr", 32'(cur_ptr), 32'h0);
    ld(3'd4); rd(8'h00, "R1 pol0"); rd(8'h00, "R1 pol1");
    ld(3'd6); rd(8'hFF, "R1 cfg0"); rd(8'hFF, "R1 cfg1");
    ld(3'd2); rd(8'h00, "R1 out0"); rd(8'h00, "R1 out1");
    chk("R2 ptr after two reads", 32'(cur_ptr), 32'd2);

    // R2, R3, R4: output and direction writes
    ld(3'd2); wr(8'hA5);
    chk("R2 ptr 2->3", 32'(cur_ptr), 32'd3);
    wr(8'h3C);
    chk("R2 ptr 3->2", 32'(cur_ptr), 32'd2);
    ld(3'd7); wr(8'hF0);
    chk("R2 ptr 7->6", 32'(cur_ptr), 32'd6);
    wr(8'h0F);
    chk("R3 pin_oe", 32'(pin_oe), 32'h0FF0);
    chk("R4 pin_out", 32'(pin_out), 32'h0CA0);

    // R5, R9: readback of the latches with differing pins
    pin_in = 16'h1234;
    ld(3'd2); rd(8'hA5, "R5 out0"); rd(8'h3C, "R5 out1");
    ld(3'd4); rd(8'h00, "R9 pol0 untouched"); rd(8'h00, "R9 pol1 untouched");

    // R6: polarity inversion
    ld(3'd4); wr(8'hFF); wr(8'h00);
    ld(3'd0); rd(8'hCB, "R6 in0 inverted"); rd(8'h12, "R6 in1 plain");

    // R7: input writes are ignored
    ld(3'd0); wr(8'h77);
    chk("R7 ptr flips", 32'(cur_ptr), 32'd1);
    wr(8'h88);
    ld(3'd0); rd(8'hCB, "R7 in0 unchanged"); rd(8'h12, "R7 in1 unchanged");
    chk("R7 pin_oe", 32'(pin_oe), 32'h0FF0);
    chk("R7 pin_out", 32'(pin_out), 32'h0CA0);

    // R8: two-edge synchronizer latency
    pin_in = 16'h5678;
    ld(3'd0);
    rd(8'hCB, "R8 old level at edge k-1");
    rd(8'h56, "R8 new level at edge k-2");

    // R10: load beats strobes
    ld(3'd2);
    ptr_load = 1'b1; ptr_idx = 3'd6; wr_stb = 1'b1; wr_data = 8'h00; rd_stb = 1'b1;
    @(negedge clk);
    ptr_load = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    chk("R10 ptr loaded", 32'(cur_ptr), 32'd6);
    chk("R10 pin_oe", 32'(pin_oe), 32'h0FF0);
    chk("R10 pin_out", 32'(pin_out), 32'h0CA0);
    chk("R10 rd_data", 32'(rd_data), 32'h56);

    // R11: write beats read
    wr_stb = 1'b1; wr_data = 8'h00; rd_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    chk("R11 pin_oe", 32'(pin_oe), 32'h0FFF);
    chk("R11 pin_out", 32'(pin_out), 32'h0CA5);
    chk("R11 rd_data", 32'(rd_data), 32'h56);
    chk("R11 ptr", 32'(cur_ptr), 32'd7);

    // R12: rd_data holds while idle
    repeat (3) @(negedge clk);
    chk("R12 rd_data hold", 32'(rd_data), 32'h56);
    ld(3'd6); rd(8'h00, "R9 cfg0"); rd(8'hF0, "R9 cfg1");
    ld(3'd0); rd(8'h87, "R6 in0 new pins");
    @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule